// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog timer that counts a slow tick (around 1 kHz) presented as a one-cycle strobe on the bus clock. Software configures it through a small register interface. It must keep restarting the count by writing a key value before the count reaches a programmable timeout. If the timeout is reached, or a restart is attempted illegally, the block emits a one-cycle system reset request. Period lengths are coded logarithmically: code n selects 8 << n ticks.

Two modes are available. In normal mode a key write is accepted at any time. An early-warning flag can raise an interrupt at a programmable point before the timeout. In window mode the interval after each restart begins with a closed window, and a key write that arrives inside it is treated as a fault. Control and configuration writes are staged on the bus side and take effect at the next tick. A busy bit reports the pending transfer. Configuration is frozen while the enable bit is set.

Top module: `winwdt`

## Requirements
- R1: After reset, every register reads zero, and `irq_o` and `rst_req_o` are low.
- R2: Register 1 holds the period code in bits [3:0]. When the enable has taken effect (register 0 bit 0) with window mode off, `rst_req_o` pulses when the counted ticks since the last restart reach 8 << code. Codes above 11 behave as 11, giving 16384 ticks.
- R3: The reset request lasts one bus cycle. The counter is then zero and keeps counting while enabled, so consecutive timeouts are exactly one period apart.
- R4: Once enable has taken effect, writing 8'hA5 to register 6 restarts the count. Writing any other value to it produces a reset request in the next cycle. Writes to register 6 while the enable is not in effect do nothing.
- R5: Window mode is register 0 bit 1, and the closed-window code is register 1 bits [7:4]; codes above 10 behave as 10. A key write while fewer than 8 << window code ticks have been counted produces a reset request. At or after that count, a key write restarts the count normally.
- R6: In window mode, if the period code is not larger than the window code, the effective period code is the window code plus one.
- R7: Register 2 bits [3:0] hold the early-warning code, clamped to 10. The flag (register 5 bit 0) is set when the counted ticks reach 8 << that code. Writing 1 to register 5 bit 0 clears the flag, but a new set in the same cycle wins. Writing bit 0 = 1 to register 3 sets the interrupt enable, and writing it to register 4 clears it. Registers 3 and 4 both read back the enable. `irq_o` equals flag AND enable.
- R8: While register 0 bit 0 reads 1, writes to registers 1 and 2 are ignored.
- R9: Register 7 bit 0 (busy) is set the cycle after an accepted write to registers 0 to 2. It clears after the next tick that is not itself a write cycle. New settings govern counting only from the tick after they were applied.
- R10: While the applied enable is off, the counter is held at zero and no reset request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe of the slow watchdog tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The checker assumes that `tick_i` is a strobe synchronous to `clk` and that at most one register write arrives per cycle. It also assumes that reset request pulses come only from a tick or a write to the key register. The bench drives each input once per cycle, away from the sampling edge. The tick pattern ranges from every cycle to absent. Write cycles are placed both with and without a coincident tick, so that the staging and locking rules are tested on both sides of each tick.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
   localparam int unsigned REG_AW = 3;
   localparam int unsigned REG_DW = 8;

   localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
   localparam logic [REG_AW-1:0] A_CFG   = 3'd1;
   localparam logic [REG_AW-1:0] A_EW    = 3'd2;
   localparam logic [REG_AW-1:0] A_IESET = 3'd3;
   localparam logic [REG_AW-1:0] A_IECLR = 3'd4;
   localparam logic [REG_AW-1:0] A_FLAG  = 3'd5;
   localparam logic [REG_AW-1:0] A_KICK  = 3'd6;
   localparam logic [REG_AW-1:0] A_STAT  = 3'd7;

   localparam logic [REG_DW-1:0] KICK_KEY = 8'hA5;

   typedef struct packed {
      logic win;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/winwdt_regs.sv
module winwdt_regs
   import winwdt_pkg::*;
#(
   parameter int unsigned CODE_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick_i,
   input  logic                   wr_en_i,
   input  logic [REG_AW-1:0]      wr_addr_i,
   input  logic [REG_DW-1:0]      wr_data_i,
   input  logic                   ew_hit_i,
   output ctrl_t                  ctrl_q,
   output logic [2*CODE_W-1:0]    cfg_q,
   output logic [CODE_W-1:0]      ew_q,
   output logic                   ie_q,
   output logic                   flag_q,
   output logic                   busy_q,
   output ctrl_t                  act_ctrl,
   output logic [CODE_W-1:0]      act_per,
   output logic [CODE_W-1:0]      act_win,
   output logic [CODE_W-1:0]      act_ew,
   output logic                   kick_o,
   output logic                   kick_ok_o
);
   localparam int unsigned CFG_W = 2 * CODE_W;

   if (CFG_W > REG_DW) begin : g_bad_code_w
      $error("winwdt_regs: two code fields must fit in one register");
   end

   logic wr_ctrl, wr_cfg, wr_ew, wr_ieset, wr_ieclr, wr_flag, sync_wr;

   always_comb begin
      wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
      wr_cfg   = wr_en_i && (wr_addr_i == A_CFG) && !ctrl_q.en;
      wr_ew    = wr_en_i && (wr_addr_i == A_EW)  && !ctrl_q.en;
      wr_ieset = wr_en_i && (wr_addr_i == A_IESET) && wr_data_i[0];
      wr_ieclr = wr_en_i && (wr_addr_i == A_IECLR) && wr_data_i[0];
      wr_flag  = wr_en_i && (wr_addr_i == A_FLAG)  && wr_data_i[0];
      sync_wr  = wr_ctrl || wr_cfg || wr_ew;
      kick_o    = wr_en_i && (wr_addr_i == A_KICK);
      kick_ok_o = (wr_data_i == KICK_KEY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         cfg_q    <= '0;
         ew_q     <= '0;
         ie_q     <= 1'b0;
         flag_q   <= 1'b0;
         busy_q   <= 1'b0;
         act_ctrl <= '0;
         act_per  <= '0;
         act_win  <= '0;
         act_ew   <= '0;
      end else begin
         if (tick_i) begin
            act_ctrl <= ctrl_q;
            act_per  <= cfg_q[CODE_W-1:0];
            act_win  <= cfg_q[CFG_W-1:CODE_W];
            act_ew   <= ew_q;
         end
         if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data_i[1:0]);
         if (wr_cfg)  cfg_q  <= wr_data_i[CFG_W-1:0];
         if (wr_ew)   ew_q   <= wr_data_i[CODE_W-1:0];
         if (wr_ieset)      ie_q <= 1'b1;
         else if (wr_ieclr) ie_q <= 1'b0;
         if (ew_hit_i)     flag_q <= 1'b1;
         else if (wr_flag) flag_q <= 1'b0;
         if (sync_wr)     busy_q <= 1'b1;
         else if (tick_i) busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/winwdt_decode.sv
module winwdt_decode #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned BASE_LOG = 3,
   parameter int unsigned MAX_PER  = 11,
   parameter int unsigned MAX_WIN  = 10,
   localparam int unsigned CNT_W   = BASE_LOG + MAX_PER
) (
   input  logic              win_mode_i,
   input  logic [CODE_W-1:0] per_raw_i,
   input  logic [CODE_W-1:0] win_raw_i,
   input  logic [CODE_W-1:0] ew_raw_i,
   output logic [CODE_W-1:0] per_eff_o,
   output logic [CODE_W-1:0] win_eff_o,
   output logic [CNT_W:0]    per_lim_o,
   output logic [CNT_W:0]    win_lim_o,
   output logic [CNT_W:0]    ew_lim_o
);
   localparam int unsigned MAX_EW = MAX_PER - 1;

   if (MAX_WIN >= MAX_PER) begin : g_bad_win
      $error("winwdt_decode: window ceiling must be below period ceiling");
   end
   if (MAX_PER >= (1 << CODE_W)) begin : g_bad_per
      $error("winwdt_decode: period ceiling does not fit the code field");
   end

   logic [CNT_W:0] pow_tab [0:MAX_PER];

   for (genvar k = 0; k <= MAX_PER; k++) begin : g_tab
      assign pow_tab[k] = (CNT_W+1)'(1) << (BASE_LOG + k);
   end

   logic [CODE_W-1:0] pc, wc, ec;

   always_comb begin
      pc = (per_raw_i > CODE_W'(MAX_PER)) ? CODE_W'(MAX_PER) : per_raw_i;
      wc = (win_raw_i > CODE_W'(MAX_WIN)) ? CODE_W'(MAX_WIN) : win_raw_i;
      ec = (ew_raw_i  > CODE_W'(MAX_EW))  ? CODE_W'(MAX_EW)  : ew_raw_i;
      if (win_mode_i && (pc <= wc)) pc = wc + CODE_W'(1);
      per_eff_o = pc;
      win_eff_o = wc;
      per_lim_o = pow_tab[pc];
      win_lim_o = pow_tab[wc];
      ew_lim_o  = pow_tab[ec];
   end
endmodule

// File: rtl/winwdt_core.sv
module winwdt_core #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             act_en_i,
   input  logic             act_win_i,
   input  logic             kick_i,
   input  logic             kick_ok_i,
   input  logic [CNT_W:0]   per_lim_i,
   input  logic [CNT_W:0]   win_lim_i,
   input  logic [CNT_W:0]   ew_lim_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             rst_req_o,
   output logic             ew_hit_o
);
   logic [CNT_W:0] inc, nxt;
   logic           req;

   always_comb begin
      inc      = {1'b0, cnt_o} + (CNT_W+1)'(1);
      nxt      = {1'b0, cnt_o};
      req      = 1'b0;
      ew_hit_o = 1'b0;
      if (!act_en_i) begin
         nxt = '0;
      end else if (kick_i) begin
         nxt = '0;
         if (!kick_ok_i || (act_win_i && ({1'b0, cnt_o} < win_lim_i))) req = 1'b1;
      end else if (tick_i) begin
         if (inc == ew_lim_i) ew_hit_o = 1'b1;
         if (inc == per_lim_i) begin
            req = 1'b1;
            nxt = '0;
         end else begin
            nxt = inc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o     <= '0;
         rst_req_o <= 1'b0;
      end else begin
         cnt_o     <= nxt[CNT_W-1:0];
         rst_req_o <= req;
      end
   end
endmodule

// File: rtl/winwdt.sv
module winwdt
   import winwdt_pkg::*;
#(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned BASE_LOG = 3,
   parameter int unsigned MAX_PER  = 11,
   parameter int unsigned MAX_WIN  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [REG_AW-1:0] wr_addr_i,
   input  logic [REG_DW-1:0] wr_data_i,
   input  logic [REG_AW-1:0] rd_addr_i,
   output logic [REG_DW-1:0] rd_data_o,
   output logic              irq_o,
   output logic              rst_req_o
);
   localparam int unsigned CNT_W = BASE_LOG + MAX_PER;

   if (BASE_LOG == 0) begin : g_bad_base
      $error("winwdt: base period must be at least two ticks");
   end

   ctrl_t               ctrl_q, act_ctrl;
   logic [2*CODE_W-1:0] cfg_q;
   logic [CODE_W-1:0]   ew_q, act_per, act_wc, act_ew;
   logic [CODE_W-1:0]   per_eff, win_eff;
   logic                ie, flag, busy, kick, kick_ok, ew_hit;
   logic                act_en, act_win, ctrl_en;
   logic [CNT_W:0]      per_lim, win_lim, ew_lim;
   logic [CNT_W-1:0]    cnt;

   winwdt_regs #(.CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .ew_hit_i(ew_hit),
      .ctrl_q(ctrl_q), .cfg_q(cfg_q), .ew_q(ew_q), .ie_q(ie),
      .flag_q(flag), .busy_q(busy), .act_ctrl(act_ctrl),
      .act_per(act_per), .act_win(act_wc), .act_ew(act_ew),
      .kick_o(kick), .kick_ok_o(kick_ok)
   );

   assign act_en  = act_ctrl.en;
   assign act_win = act_ctrl.win;
   assign ctrl_en = ctrl_q.en;

   winwdt_decode #(
      .CODE_W(CODE_W), .BASE_LOG(BASE_LOG), .MAX_PER(MAX_PER), .MAX_WIN(MAX_WIN)
   ) u_dec (
      .win_mode_i(act_win), .per_raw_i(act_per), .win_raw_i(act_wc),
      .ew_raw_i(act_ew), .per_eff_o(per_eff), .win_eff_o(win_eff),
      .per_lim_o(per_lim), .win_lim_o(win_lim), .ew_lim_o(ew_lim)
   );

   winwdt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .act_en_i(act_en), .act_win_i(act_win),
      .kick_i(kick), .kick_ok_i(kick_ok),
      .per_lim_i(per_lim), .win_lim_i(win_lim), .ew_lim_i(ew_lim),
      .cnt_o(cnt), .rst_req_o(rst_req_o), .ew_hit_o(ew_hit)
   );

   assign irq_o = flag & ie;

   always_comb begin
      case (rd_addr_i)
         A_CTRL:           rd_data_o = REG_DW'(ctrl_q);
         A_CFG:            rd_data_o = REG_DW'(cfg_q);
         A_EW:             rd_data_o = REG_DW'(ew_q);
         A_IESET, A_IECLR: rd_data_o = REG_DW'(ie);
         A_FLAG:           rd_data_o = REG_DW'(flag);
         A_STAT:           rd_data_o = REG_DW'(busy);
         default:          rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk
   import winwdt_pkg::*;
#(
   parameter int unsigned CNT_W  = 14,
   parameter int unsigned CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              wr_en_i,
   input logic [REG_AW-1:0] wr_addr_i,
   input logic              rst_req_o,
   input logic [CNT_W-1:0]  cnt,
   input logic              act_en,
   input logic              act_win,
   input logic              busy,
   input logic              flag,
   input logic              ctrl_en,
   input logic [2*CODE_W-1:0] cfg_q,
   input logic [CODE_W-1:0] per_eff,
   input logic [CODE_W-1:0] win_eff
);
   p_cnt_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> (cnt == '0));

   p_pulse_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> ($past(tick_i) || ($past(wr_en_i) && ($past(wr_addr_i) == A_KICK))));

   p_window_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_win |-> (per_eff > win_eff));

   p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(tick_i) && $past(act_en)));

   p_cfg_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && wr_en_i && (wr_addr_i == A_CFG)) |=> $stable(cfg_q));

   p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick_i));

   p_idle_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(act_en) |-> (cnt == '0));

   p_idle_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(act_en) |-> !rst_req_o);
endmodule

bind winwdt winwdt_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
   .wr_addr_i(wr_addr_i), .rst_req_o(rst_req_o), .cnt(cnt),
   .act_en(act_en), .act_win(act_win), .busy(busy), .flag(flag),
   .ctrl_en(ctrl_en), .cfg_q(cfg_q), .per_eff(per_eff), .win_eff(win_eff)
);

// File: tb/winwdt_test.sv
module winwdt_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [2:0] rd_addr_i = '0;
   logic [7:0] rd_data_o;
   logic       irq_o, rst_req_o;

   winwdt uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   always #10 clk = ~clk;

   int total = 0, bad = 0;
   string phase = "R1";
   bit done = 0;

   // behavioural reference state
   int m_en, m_win, m_per, m_wc, m_ew, m_ie, m_flag, m_busy;
   int a_en, a_win, a_per, a_wc, a_ew, m_cnt, m_req;

   function automatic int pw(int c);
      return 8 << c;
   endfunction

   function automatic int model_read(int a);
      case (a)
         0: return m_win * 2 + m_en;
         1: return m_wc * 16 + m_per;
         2: return m_ew;
         3, 4: return m_ie;
         5: return m_flag;
         7: return m_busy;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_win = 0; m_per = 0; m_wc = 0; m_ew = 0; m_ie = 0; m_flag = 0;
         m_busy = 0; a_en = 0; a_win = 0; a_per = 0; a_wc = 0; a_ew = 0; m_cnt = 0; m_req = 0;
      end else begin
         int pc, wc, ec, hit, req, d, lock, syncw;
         d = int'(wr_data_i);
         pc = (a_per > 11) ? 11 : a_per;
         wc = (a_wc > 10) ? 10 : a_wc;
         ec = (a_ew > 10) ? 10 : a_ew;
         if (a_win != 0 && pc <= wc) pc = wc + 1;
         hit = 0; req = 0;
         if (a_en == 0) m_cnt = 0;
         else if (wr_en_i && wr_addr_i == 6) begin
            if (d != 8'hA5 || (a_win != 0 && m_cnt < pw(wc))) req = 1;
            m_cnt = 0;
         end else if (tick_i) begin
            if (m_cnt + 1 == pw(ec)) hit = 1;
            if (m_cnt + 1 == pw(pc)) begin req = 1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
         end
         m_req = req;
         if (tick_i) begin
            a_en = m_en; a_win = m_win; a_per = m_per; a_wc = m_wc; a_ew = m_ew;
         end
         lock = m_en; syncw = 0;
         if (wr_en_i) begin
            case (int'(wr_addr_i))
               0: begin m_en = d % 2; m_win = (d / 2) % 2; syncw = 1; end
               1: if (lock == 0) begin m_per = d % 16; m_wc = (d / 16) % 16; syncw = 1; end
               2: if (lock == 0) begin m_ew = d % 16; syncw = 1; end
               3: if (d % 2 == 1) m_ie = 1;
               4: if (d % 2 == 1) m_ie = 0;
               default: ;
            endcase
         end
         if (hit) m_flag = 1;
         else if (wr_en_i && wr_addr_i == 5 && d % 2 == 1) m_flag = 0;
         if (syncw) m_busy = 1;
         else if (tick_i) m_busy = 0;
      end
   end

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   bit seen_req;
   int last_rd, rd_ptr = 0, pulses = 0;

   task automatic step(input bit tk, input bit we, input int a, input int d, input int ra);
      @(negedge clk);
      if (rst_n) begin
         chk({phase, " rd"}, int'(rd_data_o), model_read(int'(rd_addr_i)));
         chk({phase, " irq"}, int'(irq_o), (m_flag != 0 && m_ie != 0) ? 1 : 0);
         chk({phase, " rst_req"}, int'(rst_req_o), m_req);
      end
      seen_req = rst_req_o;
      if (rst_req_o) pulses++;
      last_rd = int'(rd_data_o);
      tick_i = tk; wr_en_i = we; wr_addr_i = 3'(a); wr_data_i = 8'(d); rd_addr_i = 3'(ra);
   endtask

   task automatic wr(int a, int d, int ra = 7);
      step(0, 1, a, d, ra);
   endtask

   task automatic run(int n, bit tk);
      for (int i = 0; i < n; i++) begin
         step(tk, 0, 0, 0, rd_ptr % 8);
         rd_ptr++;
      end
   endtask

   task automatic gap(output int n);
      int guard = 0;
      seen_req = 0;
      while (!seen_req && guard < 40000) begin run(1, 1); guard++; end
      n = 0;
      do begin run(1, 1); n++; end while (!seen_req && n < 40000);
   endtask

   task automatic reconfig(int cfg, int ctrl);
      wr(0, 0); run(1, 1); run(1, 0);
      wr(1, cfg); wr(0, ctrl); run(1, 1); run(1, 0);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values of all registers
      for (int a = 0; a < 8; a++) begin
         step(0, 0, 0, 0, a);
         if (a > 0) chk("R1 reset readback", last_rd, 0);
      end
      step(0, 0, 0, 0, 0);
      chk("R1 reset readback", last_rd, 0);
      chk("R1 rst_req idle", int'(rst_req_o), 0);

      // R9: busy set by a config write, cleared after next tick
      phase = "R9";
      wr(1, 8'h02);
      step(1, 0, 0, 0, 7);
      chk("R9 busy after write", last_rd, 1);
      step(0, 0, 0, 0, 7);
      chk("R9 busy after tick", last_rd, 0);
      wr(2, 8'h01); wr(3, 1); wr(0, 1);
      run(1, 1);

      // R2/R3: period code 2 -> 32 ticks between requests
      phase = "R2";
      gap(n);
      chk("R2 R3 period code 2", n, 32);
      // R7: early warning at 16 ticks raised the interrupt
      phase = "R7";
      chk("R7 irq raised", int'(irq_o), 1);
      wr(5, 1); run(1, 0);
      chk("R7 flag cleared", int'(irq_o), 0);
      wr(4, 1); run(40, 1);
      step(0, 0, 0, 0, 5); step(0, 0, 0, 0, 5);
      chk("R7 flag set with irq masked", last_rd, 1);
      chk("R7 irq masked", int'(irq_o), 0);
      wr(5, 1);

      // R8: config locked while enabled
      phase = "R8";
      wr(1, 8'h05);
      wr(2, 8'h07, 1);
      step(0, 0, 0, 0, 2);
      chk("R8 cfg unchanged", last_rd, 8'h02);
      step(0, 0, 0, 0, 2);
      chk("R8 ew unchanged", last_rd, 8'h01);
      gap(n);
      chk("R8 period unchanged", n, 32);

      // R4: keyed restarts keep it quiet, wrong key forces a request
      phase = "R4";
      pulses = 0;
      for (int k = 0; k < 6; k++) begin run(20, 1); wr(6, 8'hA5); end
      run(1, 0);
      chk("R4 no request with key", pulses, 0);
      wr(6, 8'h5A); run(1, 0);
      chk("R4 wrong key request", int'(seen_req), 1);

      // R10: disabled counter is inert, kicks ignored
      phase = "R10";
      wr(0, 0); run(1, 1);
      pulses = 0;
      run(100, 1); wr(6, 8'h00); run(2, 0);
      chk("R10 R4 no request while disabled", pulses, 0);

      // R5: window mode, win code 1 (16), per code 2 (32)
      phase = "R5";
      wr(1, 8'h12); wr(0, 3); run(1, 1);
      run(5, 1); wr(6, 8'hA5); run(1, 0);
      chk("R5 kick in closed window", int'(seen_req), 1);
      run(20, 1); wr(6, 8'hA5); run(1, 0);
      chk("R5 kick in open window", int'(seen_req), 0);
      run(16, 1); wr(6, 8'hA5); run(1, 0);
      chk("R5 kick at window edge", int'(seen_req), 0);
      gap(n);
      chk("R5 window timeout", n, 32);

      // R6: per code 1 under window code 3 -> effective code 4
      phase = "R6";
      reconfig(8'h31, 3);
      gap(n);
      chk("R6 stretched period", n, 128);

      // R2: code 12 clamps to 11
      phase = "R2";
      reconfig(8'h0C, 1);
      gap(n);
      chk("R2 clamped period", n, 16384);

      // R5: window code 15 clamps to 10 (8192), period 15 -> 11
      phase = "R5";
      reconfig(8'hFF, 3);
      gap(n);
      run(8190, 1); wr(6, 8'hA5); run(1, 0);
      chk("R5 clamped window early", int'(seen_req), 1);
      run(8192, 1); wr(6, 8'hA5); run(1, 0);
      chk("R5 clamped window open", int'(seen_req), 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired phase=%s act=running exp=finished", phase);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule